// File: doc/BRIEF.md
# Misaligned Load Data Aligner

This block sits between a load/store unit and the memory bus on the load return path. For each load it takes the full target address, a two-bit access kind and the raw 32-bit word returned by the bus. From these it produces two things. The first is the address to present to the bus, with its low bits cleared as the access kind needs. The second is the 32-bit value to write into the destination register. A misaligned word or halfword load does not fault: the data is rotated right by eight bits for each byte of misalignment. A signed halfword load at an odd address becomes a sign-extended byte load.

Load requests enter on a valid/ready stream and results leave on a second valid/ready stream. A request transfers on a cycle where `in_valid` and `in_ready` are both high, and a result transfers on a cycle where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the result and `out_valid` hold steady and `in_ready` is low, so back-pressure reaches the producer.

The parameter `REG_OUT` selects how the result side is built. With `REG_OUT=1`, the default, there is one register stage, and `in_ready` is high when the stage is empty or is draining that cycle. With `REG_OUT=0`, the path is purely combinational and `in_ready` follows `out_ready`. Bus data is little-endian: byte lane n of the word occupies bits 8n+7:8n.

Top module: `ld_align_top`

## Requirements
- R1: `bus_addr` is `in_addr` with bits 1:0 cleared for kind 0 (word) and kind 3 (reserved). It has bit 0 cleared for kind 1 (unsigned half), and for kind 2 (signed half) at an even address. It equals `in_addr` unchanged for a kind 2 load at an odd address.
- R2: For kind 0, the result is the bus word rotated right by 8 × `in_addr[1:0]` bits. Offset 0 passes the word through unchanged.
- R3: For kind 1 at an even address, the result is the halfword lane chosen by `in_addr[1]` (0 selects bits 15:0, 1 selects bits 31:16), zero-extended to 32 bits.
- R4: For kind 1 at an odd address, the zero-extended halfword from the lane chosen by `in_addr[1]` is rotated right by 8 bits.
- R5: For kind 2 at an even address, the halfword lane chosen by `in_addr[1]` is sign-extended to 32 bits.
- R6: For kind 2 at an odd address, the byte lane chosen by `in_addr[1:0]` is sign-extended to 32 bits.
- R7: For kind 3, the result is zero whatever the bus data.
- R8: With `REG_OUT=1`, an accepted request's result appears with `out_valid` on the cycle after acceptance. While `out_valid` is high and `out_ready` is low, `out_data` and `out_valid` hold and `in_ready` is low.
- R9: During and straight after reset, `out_valid` is low and `out_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Load request present |
| in_ready | output | 1 | Block can accept a request |
| in_addr | input | ADDR_W | Full load address |
| in_kind | input | 2 | 0 word, 1 unsigned half, 2 signed half, 3 reserved |
| in_data | input | 32 | Raw word returned by the bus |
| bus_addr | output | ADDR_W | Aligned address to present to the bus |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer accepts the result |
| out_data | output | 32 | Value for the destination register |

## Verification
The bench drives every pairing of access kind and byte offset, and adds random addresses and data. Sign-extension cases use bus data whose selected byte or halfword has its top bit set.

Each directed case targets a specific mistake:
- A rotation written as a left rotation, or driven by the wrong offset bits, gives the wrong byte order at offsets 1 and 3.
- A halfword lane chosen by bit 0 rather than bit 1 reads the wrong half.
- A signed odd load that stays a halfword load shows the neighbouring byte in bits 15:8.
- A missed zero on the reserved code lets bus data leak through.

A stall with `out_ready` held low checks the back-pressure rule: a stage that overwrote its result would change `out_data` before the consumer took it.

// File: rtl/ld_align_pkg.sv
package ld_align_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned LANES  = DATA_W / 8;

  typedef enum logic [1:0] {
    KIND_WORD  = 2'd0,
    KIND_UHALF = 2'd1,
    KIND_SHALF = 2'd2,
    KIND_RSVD  = 2'd3
  } ld_kind_e;
endpackage

// File: rtl/ld_addr_align.sv
module ld_addr_align
  import ld_align_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  ld_kind_e          kind,
  output logic [ADDR_W-1:0] aligned
);
  always_comb begin
    aligned = addr;
    unique case (kind)
      KIND_WORD, KIND_RSVD: aligned[1:0] = 2'b00;
      KIND_UHALF:           aligned[0]   = 1'b0;
      KIND_SHALF:           if (!addr[0]) aligned[0] = 1'b0;
      default:              aligned = addr;
    endcase
  end
endmodule

// File: rtl/ld_data_fmt.sv
module ld_data_fmt
  import ld_align_pkg::*;
(
  input  logic [1:0]        off,
  input  ld_kind_e          kind,
  input  logic [DATA_W-1:0] raw,
  output logic [DATA_W-1:0] res
);
  localparam int unsigned HALF_W = DATA_W / 2;

  // one rotated copy of the bus word per possible byte offset
  logic [DATA_W-1:0] rot [LANES];
  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_rot
      if (g == 0) begin : g_zero
        assign rot[g] = raw;
      end else begin : g_nz
        assign rot[g] = {raw[8*g-1:0], raw[DATA_W-1:8*g]};
      end
    end
  endgenerate

  logic [HALF_W-1:0] half;
  logic [7:0]        byte_l;
  logic [DATA_W-1:0] half_z;

  always_comb begin
    half   = off[1] ? raw[DATA_W-1:HALF_W] : raw[HALF_W-1:0];
    byte_l = raw[8*off +: 8];
    half_z = {{(DATA_W-HALF_W){1'b0}}, half};
  end

  always_comb begin
    res = '0;
    unique case (kind)
      KIND_WORD:  res = rot[off];
      KIND_UHALF: res = off[0] ? {half_z[7:0], half_z[DATA_W-1:8]} : half_z;
      KIND_SHALF: res = off[0] ? {{(DATA_W-8){byte_l[7]}}, byte_l}
                               : {{(DATA_W-HALF_W){half[HALF_W-1]}}, half};
      default:    res = '0;
    endcase
  end
endmodule

// File: rtl/ld_out_stage.sv
module ld_out_stage
  import ld_align_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_valid,
  output logic              up_ready,
  input  logic [DATA_W-1:0] up_data,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic [DATA_W-1:0] dn_data
);
  generate
    if (REG_OUT) begin : g_reg
      logic              v_q;
      logic [DATA_W-1:0] d_q;
      assign up_ready = !v_q || dn_ready;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          v_q <= 1'b0;
          d_q <= '0;
        end else if (up_ready) begin
          v_q <= up_valid;
          if (up_valid) d_q <= up_data;
        end
      end
      assign dn_valid = v_q;
      assign dn_data  = d_q;
    end else begin : g_pass
      assign up_ready = dn_ready;
      assign dn_valid = up_valid;
      assign dn_data  = up_data;
    end
  endgenerate
endmodule

// File: rtl/ld_align_top.sv
module ld_align_top
  import ld_align_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [1:0]        in_kind,
  input  logic [DATA_W-1:0] in_data,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  ld_kind_e          kind;
  logic [DATA_W-1:0] fmt;

  assign kind = ld_kind_e'(in_kind);

  ld_addr_align #(.ADDR_W(ADDR_W)) u_addr (
    .addr    (in_addr),
    .kind    (kind),
    .aligned (bus_addr)
  );

  ld_data_fmt u_fmt (
    .off  (in_addr[1:0]),
    .kind (kind),
    .raw  (in_data),
    .res  (fmt)
  );

  ld_out_stage #(.REG_OUT(REG_OUT)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_valid (in_valid),
    .up_ready (in_ready),
    .up_data  (fmt),
    .dn_valid (out_valid),
    .dn_ready (out_ready),
    .dn_data  (out_data)
  );
endmodule

// File: rtl/ld_align_chk.sv
module ld_align_chk
  import ld_align_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter bit          REG_OUT = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [ADDR_W-1:0] in_addr,
  input logic [1:0]        in_kind,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data
);
  // R1: word and reserved accesses reach the bus word-aligned
  a_r1_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (in_kind == 2'd0 || in_kind == 2'd3) |-> bus_addr[1:0] == 2'b00);

  // R6: a signed odd load keeps its byte address
  a_r6_byte_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (in_kind == 2'd2 && in_addr[0]) |-> bus_addr == in_addr);

  generate
    if (REG_OUT) begin : g_reg_chk
      // R8: a stalled result holds steady
      a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

      // R8: back-pressure reaches the producer
      a_r8_backpress: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

      // R7: reserved code gives zero on the next result
      a_r7_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_kind == 2'd3) |=> (out_valid && out_data == '0));

      // R9: reset empties the stage
      a_r9_reset_empty: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_data == '0));
    end
  endgenerate
endmodule

bind ld_align_top ld_align_chk #(.ADDR_W(ADDR_W), .REG_OUT(REG_OUT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_addr   (in_addr),
  .in_kind   (in_kind),
  .bus_addr  (bus_addr),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data)
);

// File: tb/tb_ld_align_top.sv
module tb_ld_align_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [ADDR_W-1:0] in_addr = '0;
  logic [1:0]        in_kind = 2'd0;
  logic [31:0]       in_data = '0;
  logic [ADDR_W-1:0] bus_addr;
  logic              out_valid;
  logic              out_ready = 1'b1;
  logic [31:0]       out_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ld_align_top #(.ADDR_W(ADDR_W), .REG_OUT(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_kind(in_kind), .in_data(in_data),
    .bus_addr(bus_addr), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  function automatic logic [ADDR_W-1:0] exp_addr(logic [ADDR_W-1:0] a, logic [1:0] k);
    if (k == 2'd2 && a[0]) return a;
    if (k == 2'd1 || k == 2'd2) return a & ~ADDR_W'(1);
    return a & ~ADDR_W'(3);
  endfunction

  function automatic logic [31:0] exp_data(logic [1:0] off, logic [1:0] k, logic [31:0] d);
    logic [63:0] dd;
    logic [15:0] h;
    logic [7:0]  b;
    dd = {d, d} >> (8 * off);
    h  = off[1] ? d[31:16] : d[15:0];
    b  = d[8*off +: 8];
    case (k)
      2'd0: return dd[31:0];
      2'd1: return off[0] ? {h[7:0], 16'h0000, h[15:8]} : {16'h0000, h};
      2'd2: return off[0] ? {{24{b[7]}}, b} : {{16{h[15]}}, h};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string req_of(logic [1:0] off, logic [1:0] k);
    case (k)
      2'd0: return "R2";
      2'd1: return off[0] ? "R4" : "R3";
      2'd2: return off[0] ? "R6" : "R5";
      default: return "R7";
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive one request at negedge, check bus address, capture, check result
  task automatic do_load(logic [ADDR_W-1:0] a, logic [1:0] k, logic [31:0] d);
    @(negedge clk);
    in_valid = 1'b1; in_addr = a; in_kind = k; in_data = d;
    #1;
    check("R1", bus_addr, exp_addr(a, k));
    @(negedge clk);
    in_valid = 1'b0;
    check("R8", {31'd0, out_valid}, 32'd1);
    check(req_of(a[1:0], k), out_data, exp_data(a[1:0], k, d));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] held;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9", {31'd0, out_valid}, 32'd0);
    check("R9", out_data, 32'd0);
    rst_n = 1'b1;

    // directed: every kind at every offset, sign bits set
    for (int k = 0; k < 4; k++)
      for (int o = 0; o < 4; o++)
        do_load(32'h1000_0100 | 32'(o), 2'(k), 32'hF28A_93C4);
    do_load(32'h0000_0003, 2'd2, 32'h7F00_0000);  // R6 positive byte
    do_load(32'h0000_0002, 2'd2, 32'h8001_7FFF);  // R5 negative upper half
    do_load(32'h0000_0003, 2'd3, 32'hFFFF_FFFF);  // R7 all ones ignored

    // R8: stall holds result and blocks input
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_addr = 32'h4; in_kind = 2'd0; in_data = 32'hA1B2_C3D4;
    @(negedge clk);
    held = out_data;
    check("R8", held, 32'hA1B2_C3D4);
    in_addr = 32'h1; in_data = 32'h1122_3344;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R8", {30'd0, out_valid, in_ready}, 32'd2);
      check("R8", out_data, held);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R8", out_data, 32'h4411_2233);
    @(negedge clk);
    check("R8", {31'd0, out_valid}, 32'd0);

    // random
    for (int i = 0; i < 400; i++)
      do_load($urandom, 2'($urandom), $urandom);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule